// File: doc/BRIEF.md
# Masked Alarm and Driver Shutdown Monitor

This block gathers a ten-bit vector of error events from the rest of an encoder interface and applies two masks to it. Each mask is independent of the other. The first mask picks the events that raise the alarm indication on an open-drain pin. The second picks the events that request shutdown of the quadrature line drivers. The alarm indication is held for a programmable minimum time, so that short faults stay visible to a slow external observer. The pin sense is selectable: the pin can be pulled low on error, or it can be released on error and pulled low otherwise.

The same pin is also read back through a synchronizer. An external device pulling it low while the block is not pulling it itself becomes an event of its own. That event can be reported and can stop the drivers. The block drives three outputs: the open-drain pull-low enable for the pad, the driver shutdown request and a registered status vector. The events themselves come from elsewhere, and the external pull-up is not part of this block.

The alarm timing is a three-state machine. IDLE means no alarm. ACTIVE means a masked event is present. HOLD means the events have cleared but the minimum time has not yet run out. The machine moves as follows:
- go_active: IDLE to ACTIVE when a masked event is seen.
- go_hold: ACTIVE to HOLD when the events clear while the timer is still running.
- go_idle_direct: ACTIVE to IDLE when the events clear and the timer is already at zero.
- re_arm: HOLD to ACTIVE when a masked event returns.
- expire: HOLD to IDLE when the timer reaches zero.

The timer is reloaded whenever a masked event bit rises.

Top module: `fault_alarm_mon`

## Requirements
- R1: `status_o` is registered one clock after its inputs. Bits 0, 1, 2, 3, 5, 7 and 8 copy `evt_i`. Bits 6 and 9 always read 0. Bit 4 carries the external pull-low event, and `evt_i[4]` is ignored.
- R2: A status bit whose `alarm_mask_i` bit is set raises the alarm. Bit 4 of that mask is excluded from this. The pad output reflects the alarm two clock edges after the event appears on `evt_i`.
- R3: When `pol_i` is 0, `pad_drive_low_o` is 1 during an alarm and 0 otherwise. When `pol_i` is 1, it is 0 during an alarm and 1 otherwise.
- R4: A masked event that lasts one cycle keeps the alarm on for `stretch_code_i*STEP_TICKS+1` cycles. Code 0 therefore gives exactly one cycle.
- R5: A newly rising masked event bit reloads the timer, even while the alarm is already on or in HOLD.
- R6: While any masked event is present, the alarm stays on whatever the timer value. After the last event clears, the alarm ends no earlier than the timer allows.
- R7: When `alarm_mask_i[4]` is 1, `zero_en_i`, delayed by one register, is ORed into the indication before the polarity is applied.
- R8: `drv_shutdown_o` is 1 exactly when some `status_o` bit is set in `shut_mask_i`. This includes bit 4, the external pull-low.
- R9: `pad_in_i` passes through a two-flop synchronizer. When it reads low, `pol_i` is 0, and the block did not drive the pad low in the current cycle or the previous two, `status_o[4]` is set three edges after the pin falls.
- R10: Events that are not in `alarm_mask_i` never change `pad_drive_low_o`.
- R11: After reset, `status_o` is 0, `drv_shutdown_o` is 0 and the alarm is off, so the pad is released when `pol_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Raw error events (bit 4 ignored) |
| zero_en_i | input | 1 | Raw zero-enable signal for observation on the pin |
| alarm_mask_i | input | 10 | Alarm event mask; bit 4 routes zero-enable to the pin |
| shut_mask_i | input | 10 | Driver shutdown mask; bit 4 selects external pull-low |
| pol_i | input | 1 | Pin sense: 0 pulls low on error, 1 releases on error |
| stretch_code_i | input | 3 | Minimum alarm time in units of STEP_TICKS cycles |
| pad_in_i | input | 1 | Level read back from the alarm pin |
| pad_drive_low_o | output | 1 | Open-drain pull-low enable for the alarm pin |
| drv_shutdown_o | output | 1 | Request to tristate the line drivers |
| status_o | output | 10 | Registered event status vector |

## Verification
The bench measures how long the alarm is held after a single-cycle pulse, using several stretch codes. A design with an off-by-one timer, or one that did not stretch at all, would give the wrong pulse count. A second event that arrives in HOLD must extend the alarm, and a design that ignored rising events would release it too early. An event held longer than the stretch must keep the alarm on until the event clears. A design that timed out during the event would drop the pin while the fault was still present. The read-back path is tested in three ways: with an external pull-low, with the reversed polarity, and while the block drives the pin itself. A design missing the self-drive guard would report its own pull-low as an external fault.

// File: rtl/fault_mon_pkg.sv
package fault_mon_pkg;
    localparam int EVT_W   = 10;
    localparam int EXT_BIT = 4;
    localparam int OBS_BIT = 4;
    localparam logic [EVT_W-1:0] USED_MASK   = 10'h1AF;
    localparam logic [EVT_W-1:0] UNUSED_MASK = 10'h240;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_HOLD   = 2'd2
    } alarm_state_t;
endpackage

// File: rtl/fault_pad_sync.sv
module fault_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/fault_event_reg.sv
module fault_event_reg
    import fault_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             ext_low_i,
    input  logic             zero_en_i,
    input  logic [EVT_W-1:0] alarm_mask_i,
    input  logic [EVT_W-1:0] shut_mask_i,
    output logic [EVT_W-1:0] status_o,
    output logic             hit_o,
    output logic             new_evt_o,
    output logic             shut_o,
    output logic             zen_o
);
    logic [EVT_W-1:0] status_d;
    logic [EVT_W-1:0] status_q;
    logic [EVT_W-1:0] masked;
    logic [EVT_W-1:0] masked_prev;
    logic [EVT_W-1:0] alarm_sel;
    logic             zen_q;

    always_comb begin
        status_d          = evt_i & USED_MASK;
        status_d[EXT_BIT] = ext_low_i;
    end

    always_comb begin
        alarm_sel          = alarm_mask_i;
        alarm_sel[OBS_BIT] = 1'b0;
        masked             = status_q & alarm_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q    <= '0;
            masked_prev <= '0;
            zen_q       <= 1'b0;
        end else begin
            status_q    <= status_d;
            masked_prev <= masked;
            zen_q       <= zero_en_i;
        end
    end

    assign status_o  = status_q;
    assign hit_o     = |masked;
    assign new_evt_o = |(masked & ~masked_prev);
    assign shut_o    = |(status_q & shut_mask_i);
    assign zen_o     = zen_q;
endmodule

// File: rtl/fault_stretch_fsm.sv
module fault_stretch_fsm
    import fault_mon_pkg::*;
#(
    parameter int STEP_TICKS = 12500,
    parameter int CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              hit_i,
    input  logic              new_evt_i,
    output logic              alarm_o
);
    localparam int MAX_CODE  = (1 << CODE_W) - 1;
    localparam int MAX_TICKS = MAX_CODE * STEP_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);

    alarm_state_t     st, nxt;
    logic [TW-1:0]    tmr;
    logic [TW-1:0]    limit;
    logic             tmr_zero;

    assign limit    = TW'(code_i) * TW'(STEP_TICKS);
    assign tmr_zero = (tmr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tmr <= '0;
        else if (new_evt_i) tmr <= limit;
        else if (!tmr_zero) tmr <= tmr - 1'b1;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: begin
                if (hit_i) nxt = S_ACTIVE;               // go_active
            end
            S_ACTIVE: begin
                if (!hit_i) begin
                    if (tmr_zero) nxt = S_IDLE;          // go_idle_direct
                    else          nxt = S_HOLD;          // go_hold
                end
            end
            S_HOLD: begin
                if (hit_i)         nxt = S_ACTIVE;       // re_arm
                else if (tmr_zero) nxt = S_IDLE;         // expire
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            S_ACTIVE, S_HOLD: alarm_o = 1'b1;
            default:          alarm_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fault_alarm_mon.sv
module fault_alarm_mon
    import fault_mon_pkg::*;
#(
    parameter int STEP_TICKS  = 12500,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        evt_i,
    input  logic              zero_en_i,
    input  logic [9:0]        alarm_mask_i,
    input  logic [9:0]        shut_mask_i,
    input  logic              pol_i,
    input  logic [CODE_W-1:0] stretch_code_i,
    input  logic              pad_in_i,
    output logic              pad_drive_low_o,
    output logic              drv_shutdown_o,
    output logic [9:0]        status_o
);
    logic                   pad_s;
    logic [SYNC_STAGES-1:0] drive_hist;
    logic                   ext_low;
    logic                   alarm_hit;
    logic                   alarm_new;
    logic                   alarm_on;
    logic                   shut;
    logic                   zen_q;
    logic                   err_pin;
    logic                   drive;

    fault_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in_i),
        .q_o   (pad_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_hist <= '0;
        else        drive_hist <= {drive_hist[SYNC_STAGES-2:0], drive};
    end

    assign ext_low = ~pad_s & ~pol_i & ~drive & ~(|drive_hist);

    fault_event_reg u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .ext_low_i    (ext_low),
        .zero_en_i    (zero_en_i),
        .alarm_mask_i (alarm_mask_i),
        .shut_mask_i  (shut_mask_i),
        .status_o     (status_o),
        .hit_o        (alarm_hit),
        .new_evt_o    (alarm_new),
        .shut_o       (shut),
        .zen_o        (zen_q)
    );

    fault_stretch_fsm #(.STEP_TICKS(STEP_TICKS), .CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (stretch_code_i),
        .hit_i     (alarm_hit),
        .new_evt_i (alarm_new),
        .alarm_o   (alarm_on)
    );

    assign err_pin         = alarm_on | (alarm_mask_i[OBS_BIT] & zen_q);
    assign drive           = pol_i ? ~err_pin : err_pin;
    assign pad_drive_low_o = drive;
    assign drv_shutdown_o  = shut;
endmodule

// File: rtl/fault_alarm_mon_chk.sv
module fault_alarm_mon_chk
    import fault_mon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] status_o,
    input logic [9:0] alarm_mask_i,
    input logic [9:0] shut_mask_i,
    input logic       pol_i,
    input logic       pad_drive_low_o,
    input logic       drv_shutdown_o,
    input logic       alarm_on,
    input logic       alarm_hit
);
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & UNUSED_MASK) == '0);

    a_r3_pol_low_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_i && !alarm_mask_i[OBS_BIT]) |-> (pad_drive_low_o == alarm_on));

    a_r3_pol_release_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i && !alarm_mask_i[OBS_BIT]) |-> (pad_drive_low_o != alarm_on));

    a_r6_event_keeps_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> alarm_on);

    a_r4_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_on) |-> !$past(alarm_hit));

    a_r9_ext_low_pol0: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[EXT_BIT] |-> !$past(pol_i));

    a_r8_shutdown_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_o & shut_mask_i)) |-> drv_shutdown_o);
endmodule

bind fault_alarm_mon fault_alarm_mon_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .status_o        (status_o),
    .alarm_mask_i    (alarm_mask_i),
    .shut_mask_i     (shut_mask_i),
    .pol_i           (pol_i),
    .pad_drive_low_o (pad_drive_low_o),
    .drv_shutdown_o  (drv_shutdown_o),
    .alarm_on        (alarm_on),
    .alarm_hit       (alarm_hit)
);

// File: tb/fault_alarm_mon_tb.sv
module fault_alarm_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 3;
    localparam int NVEC       = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] evt = '0;
    logic       zero_en = 1'b0;
    logic [9:0] amask = '0;
    logic [9:0] smask = '0;
    logic       pol = 1'b0;
    logic [2:0] code = '0;
    logic       ext_pull = 1'b0;
    logic       pad_in;
    logic       drive_low;
    logic       shut;
    logic [9:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pad_in = ~(drive_low | ext_pull);

    fault_alarm_mon #(.STEP_TICKS(STEP)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_i           (evt),
        .zero_en_i       (zero_en),
        .alarm_mask_i    (amask),
        .shut_mask_i     (smask),
        .pol_i           (pol),
        .stretch_code_i  (code),
        .pad_in_i        (pad_in),
        .pad_drive_low_o (drive_low),
        .drv_shutdown_o  (shut),
        .status_o        (status)
    );

    // evt, amask, smask, pol, expected drive, expected shutdown
    typedef struct packed {
        logic [9:0] e;
        logic [9:0] am;
        logic [9:0] sm;
        logic       p;
        logic       xd;
        logic       xs;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{10'h001, 10'h001, 10'h000, 1'b0, 1'b1, 1'b0},
        '{10'h001, 10'h002, 10'h001, 1'b0, 1'b0, 1'b1},
        '{10'h002, 10'h002, 10'h000, 1'b1, 1'b0, 1'b0},
        '{10'h040, 10'h3EF, 10'h3EF, 1'b0, 1'b0, 1'b0},
        '{10'h010, 10'h3EF, 10'h3FF, 1'b0, 1'b0, 1'b0},
        '{10'h180, 10'h100, 10'h080, 1'b0, 1'b1, 1'b1},
        '{10'h020, 10'h000, 10'h000, 1'b1, 1'b1, 1'b0},
        '{10'h200, 10'h200, 10'h200, 1'b0, 1'b0, 1'b0},
        '{10'h00C, 10'h008, 10'h004, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Apply events for len cycles, count samples with the alarm pin driven
    task automatic count_alarm(input logic [9:0] e, input int len, output int cnt);
        cnt = 0;
        evt = e;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (drive_low) cnt++;
            if (k == len - 1) evt = '0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 status in reset", 32'(status), 0);
        check("R11 shutdown in reset", 32'(shut), 0);
        check("R11 pad in reset", 32'(drive_low), 0);
        rst_n = 1'b1;
        step(3);
        check("R11 pad after reset", 32'(drive_low), 0);

        // R1: status mapping, bit 4 input ignored, bits 6 and 9 zero
        evt = 10'h3FF;
        step(1);
        check("R1 status map", 32'(status), 32'h1AF);
        evt = '0;
        step(3);

        // Vector table: masks, polarity, shutdown (R2 R3 R8 R10), code 0
        for (int v = 0; v < NVEC; v++) begin
            pol = VECS[v].p; amask = VECS[v].am; smask = VECS[v].sm;
            evt = VECS[v].e;
            step(2);
            check("R2/R3/R10 vector pad", 32'(drive_low), 32'(VECS[v].xd));
            check("R8 vector shutdown", 32'(shut), 32'(VECS[v].xs));
            evt = '0;
            step(4);
        end

        // R4: stretch length for single pulses
        pol = 1'b0; amask = 10'h003; smask = '0;
        step(4);
        code = 3'd0;
        count_alarm(10'h001, 1, cnt);
        check("R4 stretch code0", 32'(cnt), 1);
        code = 3'd2;
        count_alarm(10'h001, 1, cnt);
        check("R4 stretch code2", 32'(cnt), 2*STEP+1);
        code = 3'd7;
        count_alarm(10'h001, 1, cnt);
        check("R4 stretch code7", 32'(cnt), 7*STEP+1);

        // R6: long event holds the alarm beyond the stretch
        code = 3'd2;
        count_alarm(10'h001, 20, cnt);
        check("R6 hold while present", 32'(cnt), 20);

        // R5: second new event during HOLD reloads the timer
        cnt = 0;
        evt = 10'h001;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (drive_low) cnt++;
            if (k == 0) evt = '0;
            if (k == 3) evt = 10'h002;
            if (k == 4) evt = '0;
        end
        check("R5 restart on new event", 32'(cnt), 2*STEP+5);

        // R7: zero-enable observation
        code = 3'd0; amask = 10'h010; zero_en = 1'b1;
        step(2);
        check("R7 zero enable routed", 32'(drive_low), 1);
        zero_en = 1'b0;
        step(2);
        check("R7 zero enable released", 32'(drive_low), 0);
        amask = 10'h003;
        step(3);

        // R9: external pull-low with polarity 0
        smask = 10'h010;
        ext_pull = 1'b1;
        step(2);
        check("R9 not yet after two edges", 32'(status[4]), 0);
        step(1);
        check("R9 ext low reported", 32'(status[4]), 1);
        check("R8 ext low shutdown", 32'(shut), 1);
        ext_pull = 1'b0;
        step(4);
        check("R9 ext low cleared", 32'(status[4]), 0);

        // R9: polarity 1 forbids the external event
        pol = 1'b1;
        ext_pull = 1'b1;
        step(5);
        check("R9 pol1 no ext event", 32'(status[4]), 0);
        check("R9 pol1 no shutdown", 32'(shut), 0);
        ext_pull = 1'b0;
        pol = 1'b0;
        step(4);

        // R9: own drive is not an external event
        code = 3'd1;
        cnt = 0;
        evt = 10'h001;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (status[4]) cnt++;
            if (k == 7) evt = '0;
        end
        check("R9 self drive ignored", 32'(cnt), 0);
        check("R9 self drive pad released", 32'(drive_low), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule